// File: doc/BRIEF.md
# Byte-Addressed Program Memory Port

This block sits between a byte-wide register bus (fed by an upstream serial slave) and three per-channel instruction stores. Each store holds sixteen 16-bit instructions. The bus side sees a flat byte space. Channel 0 owns byte addresses 0-31, channel 1 owns 32-63 and channel 2 owns 64-95. Within a channel, word `n` sits at the byte pair `2n` (high byte) and `2n+1` (low byte).

A byte pointer advances by one after every byte transfer. A whole program, or all three programs back to back, can therefore be streamed in one burst after a single address load. Writes are assembled in pairs. The high byte is parked in a holding register, and the full word is committed when the low byte arrives. A channel's store can be read or written from the bus only while that channel's load-mode bit is set. Other accesses are dropped, and reads of them return zero.

A separate read port lets the instruction sequencer fetch any word of any channel at any time.

Top module: `prog_mem_port`

## Requirements
- R1: A write to an even byte address of a loading channel changes no stored word. The next odd-address write to that channel commits the word {held high byte, new byte} at word index (address mod 32)/2.
- R2: The byte pointer advances by one after every write or read strobe, whether or not the access was allowed. `ptr_load` replaces the pointer, and an access in the same cycle uses the loaded address. A burst runs on across channel boundaries.
- R3: After an access at byte address 95, the pointer continues at address 0.
- R4: A write to a channel whose `load_mode` bit is clear leaves its store unchanged. Bit i of `load_mode` belongs to channel i.
- R5: A read of a loading channel returns the stored word's high byte for an even address and its low byte for an odd address. The byte appears on `rd_byte` one cycle after `rd_en`, with `rd_valid` high for that cycle.
- R6: A read of a non-loading channel, or of an address from 96 to 127, returns 0x00 with `rd_valid` high.
- R7: When `wr_en` and `rd_en` are both high, only the write is performed. No `rd_valid` follows, and the pointer advances once.
- R8: `seq_instr` shows the word at (`seq_ch`, `seq_pc`) one cycle later, regardless of load mode. A word committed in the same cycle shows its old value. `seq_ch` = 3 yields 0.
- R9: Under reset, `rd_byte`, `rd_valid` and `seq_instr` are 0. After reset the pointer is 0 and the holding register is 0, so a lone odd write commits {0x00, byte}.
- R10: `rd_byte` keeps its last value in every cycle without `rd_valid`.
- R11: Writes to addresses 96-127 change no store. The pointer wraps from 127 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_mode | input | 3 | Per-channel load-mode enable, bit i = channel i |
| ptr_load | input | 1 | Load the byte pointer from `ptr_addr` |
| ptr_addr | input | 7 | Byte address to load |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wr_byte | input | 8 | Write data byte |
| rd_byte | output | 8 | Read data byte |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| seq_ch | input | 2 | Sequencer channel select |
| seq_pc | input | 4 | Sequencer word index |
| seq_instr | output | 16 | Instruction word for the sequencer |

## Verification
A pointer that skips or repeats a step shows up on the very next read burst: every following byte is shifted by one position. A stale or wrongly cleared holding register shows up only when the word is read back, as a corrupted high byte paired with the correct low byte. A broken load-mode gate shows up either as non-zero bytes from a channel that is not loading, or as a word changed by a write that should have been dropped; the latter becomes visible on the sequencer port one cycle after the commit. The reference model tracks pointer, holding byte and every stored word, and is compared against all outputs on every clock.

// File: rtl/pmp_pkg.sv
`timescale 1ns/1ps
package pmp_pkg;
  parameter int unsigned PMP_NUM_CH = 3;
  parameter int unsigned PMP_DEPTH  = 16;
  parameter int unsigned PMP_BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2
  } acc_e;
endpackage

// File: rtl/pmp_addr_ctrl.sv
`timescale 1ns/1ps
module pmp_addr_ctrl #(
  parameter int unsigned AW    = 7,
  parameter int unsigned TOTAL = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_addr,
  input  logic          step,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] ptr_q
);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

  logic [AW-1:0] ptr_nxt;

  always_comb begin
    eff_addr = ptr_load ? ptr_addr : ptr_q;
    if (!step)
      ptr_nxt = eff_addr;
    else if (eff_addr == LAST)
      ptr_nxt = '0;
    else
      ptr_nxt = eff_addr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_nxt;
  end
endmodule

// File: rtl/pmp_decode.sv
`timescale 1ns/1ps
module pmp_decode #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned PCW    = 4,
  parameter int unsigned CHW    = 2,
  parameter int unsigned AW     = 7
) (
  input  logic [AW-1:0]     eff_addr,
  input  logic [NUM_CH-1:0] load_mode,
  output logic [CHW-1:0]    ch_sel,
  output logic [PCW-1:0]    word_idx,
  output logic              lo_sel,
  output logic [NUM_CH-1:0] ch_en
);
  localparam int unsigned OFFW = PCW + 1;

  assign ch_sel   = eff_addr[AW-1:OFFW];
  assign word_idx = eff_addr[OFFW-1:1];
  assign lo_sel   = eff_addr[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_en
    assign ch_en[c] = (ch_sel == CHW'(c)) && load_mode[c];
  end
endmodule

// File: rtl/pmp_wr_asm.sv
`timescale 1ns/1ps
module pmp_wr_asm #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_ok,
  input  logic                lo_sel,
  input  logic [BYTE_W-1:0]   wr_byte,
  output logic                commit,
  output logic [2*BYTE_W-1:0] word
);
  logic [BYTE_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)
      hold_q <= '0;
    else if (wr_ok && !lo_sel)
      hold_q <= wr_byte;
  end

  assign commit = wr_ok && lo_sel;
  assign word   = {hold_q, wr_byte};
endmodule

// File: rtl/pmp_chan_mem.sv
`timescale 1ns/1ps
module pmp_chan_mem #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned PCW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              a_re,
  input  logic [PCW-1:0]    a_addr,
  input  logic [WORD_W-1:0] wd,
  output logic [WORD_W-1:0] a_q,
  input  logic [PCW-1:0]    b_addr,
  output logic [WORD_W-1:0] b_q
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a_addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)       a_q <= '0;
    else if (a_re) a_q <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) b_q <= '0;
    else     b_q <= mem[b_addr];
  end
endmodule

// File: rtl/prog_mem_port.sv
`timescale 1ns/1ps
module prog_mem_port
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_CH = PMP_NUM_CH,
  parameter int unsigned DEPTH  = PMP_DEPTH,
  parameter int unsigned BYTE_W = PMP_BYTE_W,
  localparam int unsigned WORD_W      = 2 * BYTE_W,
  localparam int unsigned PCW         = $clog2(DEPTH),
  localparam int unsigned OFFW        = PCW + 1,
  localparam int unsigned CHW         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned AW          = OFFW + CHW,
  localparam int unsigned TOTAL_BYTES = NUM_CH * DEPTH * 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] load_mode,
  input  logic              ptr_load,
  input  logic [AW-1:0]     ptr_addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_valid,
  input  logic [CHW-1:0]    seq_ch,
  input  logic [PCW-1:0]    seq_pc,
  output logic [WORD_W-1:0] seq_instr
);
  acc_e              acc;
  logic [AW-1:0]     eff_addr;
  logic [AW-1:0]     cur_ptr;
  logic [CHW-1:0]    ch_sel;
  logic [PCW-1:0]    word_idx;
  logic              lo_sel;
  logic [NUM_CH-1:0] ch_en;
  logic              any_en;
  logic              commit;
  logic [WORD_W-1:0] commit_word;
  logic [WORD_W-1:0] a_q [NUM_CH];
  logic [WORD_W-1:0] b_q [NUM_CH];

  logic              rd_ok_q;
  logic              rd_lo_q;
  logic [CHW-1:0]    rd_ch_q;
  logic [CHW-1:0]    seq_ch_q;

  always_comb begin
    if (wr_en)      acc = ACC_WRITE;
    else if (rd_en) acc = ACC_READ;
    else            acc = ACC_IDLE;
  end

  pmp_addr_ctrl #(.AW(AW), .TOTAL(TOTAL_BYTES)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .ptr_load (ptr_load),
    .ptr_addr (ptr_addr),
    .step     (acc != ACC_IDLE),
    .eff_addr (eff_addr),
    .ptr_q    (cur_ptr)
  );

  pmp_decode #(.NUM_CH(NUM_CH), .PCW(PCW), .CHW(CHW), .AW(AW)) u_dec (
    .eff_addr  (eff_addr),
    .load_mode (load_mode),
    .ch_sel    (ch_sel),
    .word_idx  (word_idx),
    .lo_sel    (lo_sel),
    .ch_en     (ch_en)
  );

  assign any_en = |ch_en;

  pmp_wr_asm #(.BYTE_W(BYTE_W)) u_asm (
    .clk     (clk),
    .rst     (rst),
    .wr_ok   ((acc == ACC_WRITE) && any_en),
    .lo_sel  (lo_sel),
    .wr_byte (wr_byte),
    .commit  (commit),
    .word    (commit_word)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pmp_chan_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_mem (
      .clk    (clk),
      .rst    (rst),
      .we     (commit && ch_en[c]),
      .a_re   ((acc == ACC_READ) && ch_en[c]),
      .a_addr (word_idx),
      .wd     (commit_word),
      .a_q    (a_q[c]),
      .b_addr (seq_pc),
      .b_q    (b_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_ok_q  <= 1'b0;
      rd_lo_q  <= 1'b0;
      rd_ch_q  <= '0;
      seq_ch_q <= '0;
    end else begin
      rd_valid <= (acc == ACC_READ);
      seq_ch_q <= seq_ch;
      if (acc == ACC_READ) begin
        rd_ok_q <= any_en;
        rd_lo_q <= lo_sel;
        rd_ch_q <= ch_sel;
      end
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_ok_q && (rd_ch_q == CHW'(c)))
        rd_byte = rd_lo_q ? a_q[c][BYTE_W-1:0] : a_q[c][WORD_W-1:BYTE_W];
    end
  end

  always_comb begin
    seq_instr = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (seq_ch_q == CHW'(c))
        seq_instr = b_q[c];
    end
  end
endmodule

// File: rtl/pmp_checker.sv
`timescale 1ns/1ps
module pmp_checker #(
  parameter int unsigned AW     = 7,
  parameter int unsigned TOTAL  = 96,
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              ptr_load,
  input logic [AW-1:0]     ptr_addr,
  input logic [NUM_CH-1:0] load_mode,
  input logic              rd_valid,
  input logic [BYTE_W-1:0] rd_byte,
  input logic [AW-1:0]     cur_ptr
);
  localparam logic [AW-1:0] LAST = AW'(TOTAL - 1);

  AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> rd_valid); // R5

  AST_WRITE_DROPS_READ: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !rd_valid); // R7

  AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && (load_mode == '0)) |=> (rd_byte == '0)); // R6

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_byte)); // R10

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && !ptr_load && (cur_ptr != LAST)) |=> (cur_ptr == $past(cur_ptr) + AW'(1))); // R2

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && !ptr_load && (cur_ptr == LAST)) |=> (cur_ptr == '0)); // R3

  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !rd_en && !ptr_load) |=> $stable(cur_ptr)); // R2

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (ptr_load && !wr_en && !rd_en) |=> (cur_ptr == $past(ptr_addr))); // R2
endmodule

bind prog_mem_port pmp_checker #(
  .AW(AW), .TOTAL(TOTAL_BYTES), .NUM_CH(NUM_CH), .BYTE_W(BYTE_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .ptr_load  (ptr_load),
  .ptr_addr  (ptr_addr),
  .load_mode (load_mode),
  .rd_valid  (rd_valid),
  .rd_byte   (rd_byte),
  .cur_ptr   (cur_ptr)
);

// File: tb/prog_mem_port_tb.sv
`timescale 1ns/1ps
module prog_mem_port_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  lm;
  logic        ld;
  logic [6:0]  addr;
  logic        wr, rd;
  logic [7:0]  wb;
  logic [7:0]  rb;
  logic        rv;
  logic [1:0]  sch;
  logic [3:0]  spc;
  logic [15:0] si;

  int checks = 0;
  int fails  = 0;

  int mem_m [3][16];
  bit mv    [3][16];
  int ptr_m  = 0;
  int hold_m = 0;
  int e_rb   = 0;
  bit e_rv   = 1'b0;

  always #2.5 clk = ~clk;

  prog_mem_port u_dut (
    .clk(clk), .rst(rst), .load_mode(lm), .ptr_load(ld), .ptr_addr(addr),
    .wr_en(wr), .rd_en(rd), .wr_byte(wb), .rd_byte(rb), .rd_valid(rv),
    .seq_ch(sch), .seq_pc(spc), .seq_instr(si)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    int eff, ch, idx, lo, e_si;
    bit allow, si_known;
    eff = ld ? int'(addr) : ptr_m;
    ch  = eff / 32;
    idx = (eff % 32) / 2;
    lo  = eff % 2;
    allow = 1'b0;
    if (ch < 3) allow = lm[ch];
    if (sch >= 2'd3) begin
      e_si = 0; si_known = 1'b1;
    end else begin
      si_known = mv[sch][spc];
      e_si     = mem_m[sch][spc];
    end
    if (wr) begin
      e_rv = 1'b0;
      if (allow) begin
        if (lo == 0) hold_m = int'(wb);
        else begin
          mem_m[ch][idx] = (hold_m << 8) | int'(wb);
          mv[ch][idx]    = 1'b1;
        end
      end
    end else if (rd) begin
      e_rv = 1'b1;
      if (allow) e_rb = lo ? (mem_m[ch][idx] & 255) : (mem_m[ch][idx] >> 8);
      else       e_rb = 0;
    end else begin
      e_rv = 1'b0;
    end
    if (wr || rd) ptr_m = (eff == 95) ? 0 : ((eff + 1) % 128);
    else          ptr_m = eff;
    @(posedge clk);
    #1;
    chk(tag, "rd_valid", int'(rv), int'(e_rv));
    chk(tag, "rd_byte", int'(rb), e_rb);
    if (si_known) chk("R8", "seq_instr", int'(si), e_si);
    @(negedge clk);
  endtask

  task automatic acc(bit l, int a, bit w, bit r, int b, string tag);
    ld = l; addr = 7'(a); wr = w; rd = r; wb = 8'(b);
    step(tag);
    ld = 1'b0; wr = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    repeat (n) step(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; lm = '0; ld = 1'b0; addr = '0; wr = 1'b0; rd = 1'b0;
    wb = '0; sch = '0; spc = '0;
    repeat (4) begin
      @(posedge clk); #1;
      chk("R9", "rd_valid", int'(rv), 0);
      chk("R9", "rd_byte", int'(rb), 0);
      chk("R9", "seq_instr", int'(si), 0);
    end
    @(negedge clk);
    rst = 1'b0;

    // R9: lone odd write after reset commits {0x00, byte}
    lm = 3'b001;
    acc(1, 1, 1, 0, 'h5A, "R9");
    idle(2, "R9");

    // R1: full burst into channel 0, then a lone high byte
    acc(1, 0, 1, 0, 11, "R1");
    for (int k = 1; k < 32; k++) acc(0, 0, 1, 0, (k * 37 + 11) & 255, "R1");
    acc(1, 2, 1, 0, 'hEE, "R1");
    acc(1, 2, 0, 1, 0, "R1");
    acc(0, 0, 0, 1, 0, "R1");

    // R5: read back channel 0, then R10 hold
    acc(1, 0, 0, 1, 0, "R5");
    for (int k = 1; k < 32; k++) acc(0, 0, 0, 1, 0, "R5");
    idle(3, "R10");

    // R6 / R4: channel not loading
    lm = 3'b000;
    acc(1, 4, 0, 1, 0, "R6");
    acc(0, 0, 0, 1, 0, "R6");
    acc(1, 0, 1, 0, 'h11, "R4");
    acc(0, 0, 1, 0, 'h22, "R4");
    lm = 3'b001;
    acc(1, 0, 0, 1, 0, "R4");
    acc(0, 0, 0, 1, 0, "R4");

    // R4: burst across the channel 0/1 boundary with only channel 1 loading
    lm = 3'b010;
    acc(1, 30, 1, 0, 'hA1, "R4");
    acc(0, 0, 1, 0, 'hA2, "R4");
    acc(0, 0, 1, 0, 'hA3, "R4");
    acc(0, 0, 1, 0, 'hA4, "R4");
    lm = 3'b011;
    acc(1, 30, 0, 1, 0, "R4");
    for (int k = 0; k < 3; k++) acc(0, 0, 0, 1, 0, "R4");

    // R2: one burst filling channels 1 and 2, then read back
    lm = 3'b110;
    acc(1, 32, 1, 0, 5, "R2");
    for (int k = 1; k < 64; k++) acc(0, 0, 1, 0, (k * 13 + 5) & 255, "R2");
    acc(1, 32, 0, 1, 0, "R2");
    for (int k = 1; k < 64; k++) acc(0, 0, 0, 1, 0, "R2");

    // R3: wrap from 95 to 0
    lm = 3'b100;
    acc(1, 94, 1, 0, 'h31, "R3");
    acc(0, 0, 1, 0, 'h32, "R3");
    acc(0, 0, 1, 0, 'h33, "R3");
    acc(0, 0, 1, 0, 'h34, "R3");
    lm = 3'b101;
    acc(1, 94, 0, 1, 0, "R3");
    for (int k = 0; k < 3; k++) acc(0, 0, 0, 1, 0, "R3");

    // R11: unmapped addresses and 127 -> 0 wrap
    lm = 3'b111;
    acc(1, 100, 1, 0, 'h55, "R11");
    acc(0, 0, 1, 0, 'h66, "R11");
    acc(1, 100, 0, 1, 0, "R11");
    acc(0, 0, 0, 1, 0, "R11");
    acc(1, 127, 0, 1, 0, "R11");
    acc(0, 0, 0, 1, 0, "R11");

    // R7: simultaneous write and read
    lm = 3'b001;
    acc(1, 10, 1, 1, 'h77, "R7");
    acc(0, 0, 0, 1, 0, "R7");
    acc(1, 11, 1, 0, 'h88, "R7");
    acc(1, 10, 0, 1, 0, "R7");
    acc(0, 0, 0, 1, 0, "R7");

    // R8: read-first on sequencer port, then full sweep
    sch = 2'd0; spc = 4'd3;
    acc(1, 6, 1, 0, 'hAB, "R8");
    acc(0, 0, 1, 0, 'hCD, "R8");
    idle(1, "R8");
    lm = 3'b000;
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 16; p++) begin
        sch = 2'(c); spc = 4'(p);
        step("R8");
      end
    end

    summary();
    $finish;
  end
endmodule